// File: doc/BRIEF.md
# Serial Port Service Request Router

This block is the control and status core of a simple asynchronous serial port. It keeps a 16-bit control word, a receive-data-ready flag, a transmit-holding-empty flag and a receive overrun flag. From these it raises service requests. Each direction is served either by one of two DMA request lines or by a single shared interrupt line. The shift registers, baud timing, framing, parity and break logic are outside this block. Their control fields are only held in the control word and passed back unchanged.

Software writes the control word through a one-cycle write strobe. The datapath around the block reports events as single-cycle pulses: a byte has arrived, the received byte has been read, the holding register has been loaded, and the shifter has taken the held byte. The flags are registered, so an event shows on the flags, and on any request it drives, one clock after its pulse. The request outputs are levels: they stay high for as long as the flag behind them is set.

Top module: `sport_req_router`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000. Receive-ready and overrun read 0 and transmit-empty reads 1. Both DMA requests and the interrupt are low.
- R2: A control write stores all written bits except bit 12, which always reads 0. The new value is visible the cycle after the strobe.
- R3: An arrival pulse sets receive-ready and a read pulse clears it, each visible one cycle later. If both pulses come in the same cycle, receive-ready stays set.
- R4: A load pulse clears transmit-empty and a drain pulse sets it. If both pulses come in the same cycle, transmit-empty ends up 0.
- R5: An arrival while receive-ready is 1 and no read is pulsed in that cycle sets the overrun flag. Only the clear input resets the flag. If a setting arrival and a clear fall in the same cycle, the set wins.
- R6: Bits 15:13 select the DMA mapping:
  - 000: none.
  - 001: receive on channel 0, transmit on channel 1.
  - 010: receive on channel 1, transmit on channel 0.
  - 011: reserved.
  - 100: receive on channel 0 only.
  - 101: receive on channel 1 only.
  - 110: transmit on channel 0 only.
  - 111: transmit on channel 1 only.
- R7: A channel mapped to receive requests while receive-ready is 1. A channel mapped to transmit requests while transmit-empty is 1. Each channel request is the OR of the directions mapped to it.
- R8: With no DMA on a direction, the interrupt is raised while the flag for that direction is set and its enable is 1. Bit 11 enables the transmit-empty interrupt and bit 10 enables the receive-ready interrupt.
- R9: When a direction is mapped to DMA, that direction never contributes to the interrupt, whatever its enable bit holds.
- R10: Encoding 011 raises no DMA request on either channel. The interrupt then follows bits 11 and 10 as if no DMA were selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| rx_arrive | input | 1 | Pulse: a received byte entered the receive register |
| rx_read | input | 1 | Pulse: the receive register was read |
| tx_load | input | 1 | Pulse: the transmit holding register was loaded |
| tx_drain | input | 1 | Pulse: the shifter took the held byte |
| ovr_clr | input | 1 | Pulse: software clears the overrun flag |
| ctl_q | output | 16 | Control word readback |
| rx_ready | output | 1 | Receive data ready flag |
| tx_empty | output | 1 | Transmit holding register empty flag |
| rx_overrun | output | 1 | Receive overrun flag |
| dma0_req | output | 1 | DMA channel 0 request |
| dma1_req | output | 1 | DMA channel 1 request |
| irq | output | 1 | Interrupt request |

## Verification
Several functions can fall in the same cycle, and each coincidence is provoked by pulsing both inputs in the same clock.

- Overrun set against software clear: while a byte is unread, a second arrival is pulsed together with `ovr_clr`. The flag must read 1 on the following cycle.
- Overrun set against receive read: an arrival is pulsed together with `rx_read` while receive-ready is set. Receive-ready must stay 1 and the overrun flag must stay 0.
- Load against drain: the two are pulsed in one cycle. Transmit-empty must read 0 afterwards.

// File: rtl/sport_req_pkg.sv
package sport_req_pkg;

    localparam int CTL_W    = 16;
    localparam int MISC_W   = 10;
    localparam int SEL_W    = 3;
    localparam int N_CH     = 2;
    localparam int RSVD_BIT = 12;
    localparam logic [CTL_W-1:0] CTL_MASK = ~(CTL_W'(1) << RSVD_BIT);

    typedef struct packed {
        logic [SEL_W-1:0]  dma_sel;
        logic              rsvd;
        logic              tx_ie;
        logic              rx_ie;
        logic [MISC_W-1:0] misc;
    } ctl_t;

    typedef struct packed {
        logic rx_on;
        logic rx_ch;
        logic tx_on;
        logic tx_ch;
    } route_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE    = 3'b000,
        SEL_RX0_TX1 = 3'b001,
        SEL_RX1_TX0 = 3'b010,
        SEL_RSVD    = 3'b011,
        SEL_RX0     = 3'b100,
        SEL_RX1     = 3'b101,
        SEL_TX0     = 3'b110,
        SEL_TX1     = 3'b111
    } dma_sel_e;

    function automatic route_t decode_route(input logic [SEL_W-1:0] sel);
        route_t r;
        r = '0;
        case (dma_sel_e'(sel))
            SEL_RX0_TX1: begin r.rx_on = 1'b1; r.rx_ch = 1'b0; r.tx_on = 1'b1; r.tx_ch = 1'b1; end
            SEL_RX1_TX0: begin r.rx_on = 1'b1; r.rx_ch = 1'b1; r.tx_on = 1'b1; r.tx_ch = 1'b0; end
            SEL_RX0:     begin r.rx_on = 1'b1; r.rx_ch = 1'b0; end
            SEL_RX1:     begin r.rx_on = 1'b1; r.rx_ch = 1'b1; end
            SEL_TX0:     begin r.tx_on = 1'b1; r.tx_ch = 1'b0; end
            SEL_TX1:     begin r.tx_on = 1'b1; r.tx_ch = 1'b1; end
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sport_ctl_reg.sv
module sport_ctl_reg
    import sport_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    ctl_t ctl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r <= '0;
        end else if (wr) begin
            ctl_r <= ctl_t'(wdata & CTL_MASK);
        end
    end

    assign ctl = ctl_r;

    // R2
    ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl == ctl_t'($past(wdata) & CTL_MASK)));

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctl));

endmodule

// File: rtl/sport_status.sv
module sport_status (
    input  logic clk,
    input  logic rst,
    input  logic rx_arrive,
    input  logic rx_read,
    input  logic tx_load,
    input  logic tx_drain,
    input  logic ovr_clr,
    output logic rx_ready,
    output logic tx_empty,
    output logic rx_overrun
);

    logic rdy_r, emp_r, ovr_r;
    logic ovr_set;

    assign ovr_set = rx_arrive && rdy_r && !rx_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_r <= 1'b0;
            emp_r <= 1'b1;
            ovr_r <= 1'b0;
        end else begin
            if (rx_arrive)       rdy_r <= 1'b1;
            else if (rx_read)    rdy_r <= 1'b0;

            if (tx_load)         emp_r <= 1'b0;
            else if (tx_drain)   emp_r <= 1'b1;

            if (ovr_set)         ovr_r <= 1'b1;
            else if (ovr_clr)    ovr_r <= 1'b0;
        end
    end

    assign rx_ready   = rdy_r;
    assign tx_empty   = emp_r;
    assign rx_overrun = ovr_r;

    // R3
    rdy_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_arrive |=> rx_ready);

    // R3
    rdy_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_read && !rx_arrive) |=> !rx_ready);

    // R4
    emp_load_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_empty);

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_arrive && rx_ready && !rx_read) |=> rx_overrun);

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

endmodule

// File: rtl/sport_route.sv
module sport_route
    import sport_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] dma_sel,
    input  logic             tx_ie,
    input  logic             rx_ie,
    input  logic             rx_ready,
    input  logic             tx_empty,
    output logic [N_CH-1:0]  dma_req,
    output logic             irq
);

    route_t rt;

    assign rt = decode_route(dma_sel);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        assign dma_req[ch] = (rt.rx_on && (rt.rx_ch == 1'(ch)) && rx_ready)
                           || (rt.tx_on && (rt.tx_ch == 1'(ch)) && tx_empty);
    end

    assign irq = (tx_ie && !rt.tx_on && tx_empty) || (rx_ie && !rt.rx_on && rx_ready);

    // R10
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_sel == 3'b011) |-> (dma_req == '0));

    // R9
    tx_dma_noirq_chk: assert property (@(posedge clk) disable iff (rst)
        ((dma_sel == 3'b110 || dma_sel == 3'b111) && !rx_ready) |-> !irq);

    // R9
    rx_dma_noirq_chk: assert property (@(posedge clk) disable iff (rst)
        ((dma_sel == 3'b100 || dma_sel == 3'b101) && !tx_empty) |-> !irq);

    // R7
    no_flag_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !tx_empty) |-> (dma_req == '0 && !irq));

endmodule

// File: rtl/sport_req_router.sv
module sport_req_router
    import sport_req_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        rx_arrive,
    input  logic        rx_read,
    input  logic        tx_load,
    input  logic        tx_drain,
    input  logic        ovr_clr,
    output logic [15:0] ctl_q,
    output logic        rx_ready,
    output logic        tx_empty,
    output logic        rx_overrun,
    output logic        dma0_req,
    output logic        dma1_req,
    output logic        irq
);

    ctl_t            ctl;
    logic [N_CH-1:0] dma_req;

    sport_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    sport_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .rx_arrive  (rx_arrive),
        .rx_read    (rx_read),
        .tx_load    (tx_load),
        .tx_drain   (tx_drain),
        .ovr_clr    (ovr_clr),
        .rx_ready   (rx_ready),
        .tx_empty   (tx_empty),
        .rx_overrun (rx_overrun)
    );

    sport_route u_route (
        .clk      (clk),
        .rst      (rst),
        .dma_sel  (ctl.dma_sel),
        .tx_ie    (ctl.tx_ie),
        .rx_ie    (ctl.rx_ie),
        .rx_ready (rx_ready),
        .tx_empty (tx_empty),
        .dma_req  (dma_req),
        .irq      (irq)
    );

    assign ctl_q    = ctl;
    assign dma0_req = dma_req[0];
    assign dma1_req = dma_req[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_q == 16'h0000 && !rx_ready && tx_empty && !rx_overrun
                 && !dma0_req && !dma1_req && !irq));

endmodule

// File: tb/sport_req_router_tb.sv
module sport_req_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        rx_arrive = 1'b0, rx_read = 1'b0, tx_load = 1'b0, tx_drain = 1'b0, ovr_clr = 1'b0;
    logic [15:0] ctl_q;
    logic        rx_ready, tx_empty, rx_overrun, dma0_req, dma1_req, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sport_req_router u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rx_arrive(rx_arrive), .rx_read(rx_read), .tx_load(tx_load),
        .tx_drain(tx_drain), .ovr_clr(ovr_clr), .ctl_q(ctl_q),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .rx_overrun(rx_overrun),
        .dma0_req(dma0_req), .dma1_req(dma1_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic a, input logic r, input logic l, input logic d, input logic c);
        rx_arrive = a; rx_read = r; tx_load = l; tx_drain = d; ovr_clr = c;
        @(posedge clk); #1;
        rx_arrive = 0; rx_read = 0; tx_load = 0; tx_drain = 0; ovr_clr = 0;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 ctl", ctl_q, 16'h0000);
        chk("R1 flags", {13'b0, rx_ready, tx_empty, rx_overrun}, 16'h0002);
        chk("R1 reqs", {13'b0, dma0_req, dma1_req, irq}, 16'h0000);
    endtask

    task automatic t_ctl;
        wr_ctl(16'hFFFF);
        chk("R2 reserved bit", ctl_q, 16'hEFFF);
        wr_ctl(16'h0A5A);
        chk("R2 pattern", ctl_q, 16'h0A5A);
        wr_ctl(16'h0000);
        chk("R2 zero", ctl_q, 16'h0000);
    endtask

    task automatic t_rx;
        step(1, 0, 0, 0, 0);
        chk("R3 arrive", {15'b0, rx_ready}, 16'h1);
        step(0, 1, 0, 0, 0);
        chk("R3 read", {15'b0, rx_ready}, 16'h0);
    endtask

    task automatic t_tx;
        step(0, 0, 1, 0, 0);
        chk("R4 load", {15'b0, tx_empty}, 16'h0);
        step(0, 0, 0, 1, 0);
        chk("R4 drain", {15'b0, tx_empty}, 16'h1);
        step(0, 0, 1, 1, 0);
        chk("R4 load+drain", {15'b0, tx_empty}, 16'h0);
        step(0, 0, 0, 1, 0);
        chk("R4 drain again", {15'b0, tx_empty}, 16'h1);
    endtask

    task automatic t_overrun;
        step(1, 0, 0, 0, 0);
        chk("R5 first arrive", {15'b0, rx_overrun}, 16'h0);
        step(1, 0, 0, 0, 0);
        chk("R5 overwrite", {15'b0, rx_overrun}, 16'h1);
        step(0, 1, 0, 0, 0);
        chk("R5 sticky after read", {15'b0, rx_overrun}, 16'h1);
        step(0, 0, 0, 0, 1);
        chk("R5 clear", {15'b0, rx_overrun}, 16'h0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        chk("R5 set beats clear", {15'b0, rx_overrun}, 16'h1);
        step(0, 0, 0, 0, 1);
        chk("R5 clear again", {15'b0, rx_overrun}, 16'h0);
        step(1, 1, 0, 0, 0);
        chk("R3 arrive+read ready", {15'b0, rx_ready}, 16'h1);
        chk("R5 arrive+read no overrun", {15'b0, rx_overrun}, 16'h0);
        step(0, 1, 0, 0, 0);
    endtask

    // expected routing from the R6 table
    task automatic t_modes;
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 3; p++) begin
                logic rr, te, e0, e1, ei;
                int rxc, txc;
                wr_ctl(16'((m << 13) | 16'h0C00));
                rr = (p != 2);
                te = (p != 1);
                if (rx_ready != rr) step(rr, !rr, 0, 0, 0);
                if (tx_empty != te) step(0, 0, !te, te, 0);
                case (m)
                    1: begin rxc = 0; txc = 1; end
                    2: begin rxc = 1; txc = 0; end
                    4: begin rxc = 0; txc = -1; end
                    5: begin rxc = 1; txc = -1; end
                    6: begin rxc = -1; txc = 0; end
                    7: begin rxc = -1; txc = 1; end
                    default: begin rxc = -1; txc = -1; end
                endcase
                e0 = (rxc == 0 && rr) || (txc == 0 && te);
                e1 = (rxc == 1 && rr) || (txc == 1 && te);
                ei = (txc < 0 && te) || (rxc < 0 && rr);
                if (m == 3)
                    chk($sformatf("R10 sel=%0d p=%0d", m, p), {13'b0, dma0_req, dma1_req, irq}, {13'b0, e0, e1, ei});
                else
                    chk($sformatf("R6 R7 R9 sel=%0d p=%0d", m, p), {13'b0, dma0_req, dma1_req, irq}, {13'b0, e0, e1, ei});
            end
        end
        step(0, 1, 0, 1, 0);
    endtask

    task automatic t_irq;
        wr_ctl(16'h0800);
        chk("R8 tx enable", {15'b0, irq}, 16'h1);
        wr_ctl(16'h0400);
        chk("R8 rx enable idle", {15'b0, irq}, 16'h0);
        step(1, 0, 0, 0, 0);
        chk("R8 rx enable ready", {15'b0, irq}, 16'h1);
        wr_ctl(16'h0000);
        chk("R8 disabled", {15'b0, irq}, 16'h0);
        wr_ctl(16'hCC00);
        chk("R9 tx dma masks tx irq", {13'b0, dma0_req, dma1_req, irq}, 16'h0005);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctl();
        t_rx();
        t_tx();
        t_overrun();
        t_modes();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule